// File: doc/BRIEF.md
# Replaying FIFO Store Buffer

This block holds retired stores in a circular queue and hands them to the committed memory level one at a time, oldest first, over a valid/ready pair. Loads never search the queue. For a small modelled set of first-level lines the block also keeps one valid bit per word. A word-wide store sets its bit when it retires. The cache data arrays sit outside the block; only the valid bits and the replay bookkeeping are kept here.

When another agent takes a line away, a control input clears that line's word bits and raises a one-cycle request for permission and fresh data. The buffered stores stay where they are. When the fresh line comes back, the block walks the queue from head to tail, one entry per cycle, and presents each store to that line on a replay port, so the cache can lay the pending data over the refill. A byte or halfword store to a line that is not fully valid cannot be merged yet. It waits in a small side buffer and enters the queue once the refill of its line has finished.

Top module: `store_buffer`

## Requirements
- R1: After reset the queue is empty (`drain_valid_o` low), `ret_ready_o`, `ctl_ready_o` and every bit of `line_valid_o` are high, and `req_o` and `replay_valid_o` are low.
- R2: Stores leave on the drain port in the order they entered the queue, with address, data and size unchanged; `drain_valid_o` is high exactly when the queue holds an entry and no walk is running.
- R3: With 16 entries held, `ret_ready_o` is low for any store that would enter the queue, even if an entry drains in the same cycle.
- R4: A retired store of size code 2 (word; 0 is byte, 1 is halfword) sets bit `line*4+word` of `line_valid_o` in the next cycle, where line is address bits [5:4] and word is bits [3:2].
- R5: An accepted invalidation (`inv_valid_i` while `ctl_ready_o`) clears the four bits of line `line_sel_i` in the next cycle and drives `req_o` high for that one cycle with `req_line_o` equal to the line. Queued stores are kept. An invalidation takes priority over a fill in the same cycle, and either one blocks retirement in that cycle.
- R6: An accepted fill (`fill_valid_i` without `inv_valid_i`) starts a walk over the N queued entries, one entry per cycle, plus one closing cycle. Every entry whose line matches is shown on the replay port, in queue order. During the walk `ret_ready_o`, `drain_valid_o` and `ctl_ready_o` are low.
- R7: Each replayed word store sets its word bit. When the walk ends, all four bits of the filled line are set.
- R8: A byte or halfword store to a line whose bits are not all set goes into a 2-entry side buffer and not into the queue. While both slots are taken, such a store sees `ret_ready_o` low.
- R9: After the walk, the side entries for the filled line enter the queue one per cycle, lowest slot first. The block then goes back to idle, so the busy time is N+2+S cycles, where S is the number of such side entries.
- R10: A byte or halfword store to a fully valid line goes straight into the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | Retiring store present |
| ret_ready_o | output | 1 | Store accepted this cycle |
| ret_addr_i | input | 12 | Byte address of store |
| ret_data_i | input | 32 | Store data |
| ret_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| drain_valid_o | output | 1 | Head entry offered to committed level |
| drain_ready_i | input | 1 | Committed level takes head |
| drain_addr_o | output | 12 | Head address |
| drain_data_o | output | 32 | Head data |
| drain_size_o | output | 2 | Head size |
| ctl_ready_o | output | 1 | Idle; invalidation or fill can be taken |
| inv_valid_i | input | 1 | Invalidate line |
| fill_valid_i | input | 1 | Refilled line has arrived |
| line_sel_i | input | 2 | Line for invalidation or fill |
| req_o | output | 1 | Permission/data request pulse |
| req_line_o | output | 2 | Line of the request |
| replay_valid_o | output | 1 | Replayed store present |
| replay_addr_o | output | 12 | Replayed address |
| replay_data_o | output | 32 | Replayed data |
| replay_size_o | output | 2 | Replayed size |
| line_valid_o | output | 16 | Word valid bits, bit line*4+word |

## Verification
Drain fields and `ret_ready_o` are combinational on the queue state and the current inputs, so the bench samples them in the same cycle it drives inputs, one time unit after the falling edge. It updates its queue model only for handshakes that complete at the next rising edge. Valid bit changes and `req_o` are registered, so they are checked at the falling edge one cycle after the invalidation or store is accepted. For a fill, the bench counts the low `ctl_ready_o` samples that start one cycle after acceptance and expects N+2+S of them. It collects the replay port on each of those samples and compares the sequence against its own filtered copy of the queue.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    size;
  } sb_entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_REL} sb_state_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
  import sb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  sb_entry_t        push_entry_i,
  input  logic             pop_i,
  output sb_entry_t        head_entry_o,
  input  logic [PTR_W-1:0] rd_off_i,
  output sb_entry_t        rd_entry_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  sb_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W:0]   rd_sum;
  logic [PTR_W-1:0] rd_idx;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign rd_sum = {1'b0, head_q} + {1'b0, rd_off_i};
  assign rd_idx = (rd_sum >= (PTR_W + 1)'(DEPTH)) ? PTR_W'(rd_sum - (PTR_W + 1)'(DEPTH))
                                                  : rd_sum[PTR_W-1:0];

  assign head_entry_o = mem_q[head_q];
  assign rd_entry_o   = mem_q[rd_idx];
  assign count_o      = cnt_q;
  assign full_o       = (cnt_q == CNT_W'(DEPTH));
  assign empty_o      = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[tail_q] <= push_entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sb_line_valid.sv
module sb_line_valid #(
  parameter int LINES = 4,
  parameter int WORDS = 4,
  localparam int LIDX_W = $clog2(LINES),
  localparam int WIDX_W = $clog2(WORDS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic [LIDX_W-1:0]      clr_line_i,
  input  logic                   fill_all_i,
  input  logic [LIDX_W-1:0]      fill_line_i,
  input  logic                   set_en_i,
  input  logic [LIDX_W-1:0]      set_line_i,
  input  logic [WIDX_W-1:0]      set_word_i,
  output logic [LINES*WORDS-1:0] valid_o,
  output logic [LINES-1:0]       all_o
);
  logic [WORDS-1:0] lv_q [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lv_q[l] <= '1;
      end else if (clr_i && clr_line_i == LIDX_W'(l)) begin
        lv_q[l] <= '0;
      end else if (fill_all_i && fill_line_i == LIDX_W'(l)) begin
        lv_q[l] <= '1;
      end else if (set_en_i && set_line_i == LIDX_W'(l)) begin
        lv_q[l][set_word_i] <= 1'b1;
      end
    end
    assign valid_o[l*WORDS +: WORDS] = lv_q[l];
    assign all_o[l] = &lv_q[l];
  end

  assert_word_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && !clr_i && !fill_all_i) |=> lv_q[$past(set_line_i)][$past(set_word_i)]);
  assert_line_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lv_q[$past(clr_line_i)] == '0));
endmodule

// File: rtl/sb_side_buf.sv
module sb_side_buf
  import sb_pkg::*;
#(
  parameter int SIDE_DEPTH = 2,
  parameter int LINE_LSB   = 4,
  parameter int LIDX_W     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  sb_entry_t         alloc_entry_i,
  output logic              full_o,
  input  logic [LIDX_W-1:0] qline_i,
  input  logic              rel_i,
  output logic              any_match_o,
  output sb_entry_t         pick_entry_o
);
  localparam int SIDX_W = (SIDE_DEPTH > 1) ? $clog2(SIDE_DEPTH) : 1;

  logic [SIDE_DEPTH-1:0] v_q;
  sb_entry_t             e_q [SIDE_DEPTH];
  logic [SIDX_W-1:0]     free_idx, pick_idx;
  logic                  pick_found;

  always_comb begin
    free_idx = '0;
    for (int i = SIDE_DEPTH - 1; i >= 0; i--) begin
      if (!v_q[i]) free_idx = SIDX_W'(i);
    end
    pick_idx   = '0;
    pick_found = 1'b0;
    for (int i = SIDE_DEPTH - 1; i >= 0; i--) begin
      if (v_q[i] && e_q[i].addr[LINE_LSB +: LIDX_W] == qline_i) begin
        pick_idx   = SIDX_W'(i);
        pick_found = 1'b1;
      end
    end
  end

  assign full_o       = &v_q;
  assign any_match_o  = pick_found;
  assign pick_entry_o = e_q[pick_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < SIDE_DEPTH; i++) e_q[i] <= '0;
    end else begin
      if (alloc_i) begin
        v_q[free_idx] <= 1'b1;
        e_q[free_idx] <= alloc_entry_i;
      end
      if (rel_i) v_q[pick_idx] <= 1'b0;
    end
  end

  assert_side_noover_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  assert_release_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |-> any_match_o);
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int LINES      = 4,
  parameter int WORDS      = 4,
  parameter int SIDE_DEPTH = 2,
  localparam int WORD_OFF  = $clog2(DW / 8),
  localparam int WIDX_W    = $clog2(WORDS),
  localparam int LIDX_W    = $clog2(LINES),
  localparam int LINE_LSB  = WORD_OFF + WIDX_W,
  localparam int PTR_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ret_valid_i,
  output logic                   ret_ready_o,
  input  logic [AW-1:0]          ret_addr_i,
  input  logic [DW-1:0]          ret_data_i,
  input  logic [1:0]             ret_size_i,
  output logic                   drain_valid_o,
  input  logic                   drain_ready_i,
  output logic [AW-1:0]          drain_addr_o,
  output logic [DW-1:0]          drain_data_o,
  output logic [1:0]             drain_size_o,
  output logic                   ctl_ready_o,
  input  logic                   inv_valid_i,
  input  logic                   fill_valid_i,
  input  logic [LIDX_W-1:0]      line_sel_i,
  output logic                   req_o,
  output logic [LIDX_W-1:0]      req_line_o,
  output logic                   replay_valid_o,
  output logic [AW-1:0]          replay_addr_o,
  output logic [DW-1:0]          replay_data_o,
  output logic [1:0]             replay_size_o,
  output logic [LINES*WORDS-1:0] line_valid_o
);
  sb_state_e         state_q;
  logic [CNT_W-1:0]  walk_idx_q, walk_cnt_q;
  logic [LIDX_W-1:0] walk_line_q;

  sb_entry_t        ret_entry, head_entry, rd_entry, side_entry, push_entry;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_full, fifo_empty, side_full, side_any;
  logic [LINES-1:0] line_all;

  logic              idle, inv_go, fill_go, to_side, ret_go, push, pop;
  logic              walk_done, replay_hit, rel_go, set_en;
  logic [LIDX_W-1:0] ret_line, set_line;
  logic [WIDX_W-1:0] set_word;

  assign ret_entry = '{addr: ret_addr_i, data: ret_data_i, size: ret_size_i};
  assign ret_line  = ret_addr_i[LINE_LSB +: LIDX_W];

  assign idle        = (state_q == ST_IDLE);
  assign ctl_ready_o = idle;
  assign inv_go      = idle && inv_valid_i;
  assign fill_go     = idle && fill_valid_i && !inv_valid_i;

  // sub-word stores wait while their line is incomplete
  assign to_side     = (ret_size_i != SZ_WORD) && !line_all[ret_line];
  assign ret_ready_o = idle && !inv_valid_i && !fill_valid_i &&
                       (to_side ? !side_full : !fifo_full);
  assign ret_go      = ret_valid_i && ret_ready_o;

  assign drain_valid_o = !fifo_empty && (state_q != ST_WALK);
  assign pop           = drain_valid_o && drain_ready_i;
  assign drain_addr_o  = head_entry.addr;
  assign drain_data_o  = head_entry.data;
  assign drain_size_o  = head_entry.size;

  assign walk_done  = (state_q == ST_WALK) && (walk_idx_q == walk_cnt_q);
  assign replay_hit = (state_q == ST_WALK) && !walk_done &&
                      (rd_entry.addr[LINE_LSB +: LIDX_W] == walk_line_q);
  assign replay_valid_o = replay_hit;
  assign replay_addr_o  = rd_entry.addr;
  assign replay_data_o  = rd_entry.data;
  assign replay_size_o  = rd_entry.size;

  assign rel_go     = (state_q == ST_REL) && side_any && !fifo_full;
  assign push       = (ret_go && !to_side) || rel_go;
  assign push_entry = rel_go ? side_entry : ret_entry;

  always_comb begin
    set_en   = 1'b0;
    set_line = ret_line;
    set_word = ret_addr_i[WORD_OFF +: WIDX_W];
    if (replay_hit) begin
      set_en   = (rd_entry.size == SZ_WORD);
      set_line = walk_line_q;
      set_word = rd_entry.addr[WORD_OFF +: WIDX_W];
    end else if (ret_go) begin
      set_en = (ret_size_i == SZ_WORD);
    end
  end

  sb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_entry_i(push_entry), .pop_i(pop),
    .head_entry_o(head_entry), .rd_off_i(walk_idx_q[PTR_W-1:0]), .rd_entry_o(rd_entry),
    .count_o(fifo_cnt), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  sb_line_valid #(.LINES(LINES), .WORDS(WORDS)) u_lv (
    .clk_i, .rst_ni,
    .clr_i(inv_go), .clr_line_i(line_sel_i),
    .fill_all_i(walk_done), .fill_line_i(walk_line_q),
    .set_en_i(set_en), .set_line_i(set_line), .set_word_i(set_word),
    .valid_o(line_valid_o), .all_o(line_all)
  );

  sb_side_buf #(.SIDE_DEPTH(SIDE_DEPTH), .LINE_LSB(LINE_LSB), .LIDX_W(LIDX_W)) u_side (
    .clk_i, .rst_ni,
    .alloc_i(ret_go && to_side), .alloc_entry_i(ret_entry), .full_o(side_full),
    .qline_i(walk_line_q), .rel_i(rel_go),
    .any_match_o(side_any), .pick_entry_o(side_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      walk_idx_q  <= '0;
      walk_cnt_q  <= '0;
      walk_line_q <= '0;
      req_o       <= 1'b0;
      req_line_o  <= '0;
    end else begin
      req_o <= inv_go;
      if (inv_go) req_line_o <= line_sel_i;
      case (state_q)
        ST_IDLE: if (fill_go) begin
          state_q     <= ST_WALK;
          walk_idx_q  <= '0;
          walk_cnt_q  <= fifo_cnt;
          walk_line_q <= line_sel_i;
        end
        ST_WALK: begin
          if (walk_done) state_q <= ST_REL;
          else           walk_idx_q <= walk_idx_q + CNT_W'(1);
        end
        ST_REL:  if (!side_any) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_line_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (line_valid_o[req_line_o*WORDS +: WORDS] == '0));
  assert_walk_line_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REL && $past(state_q) == ST_WALK) |-> line_all[walk_line_q]);
  assert_walk_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK) |-> (walk_idx_q <= walk_cnt_q));
  assert_walk_no_drain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WALK) |=> $stable(fifo_cnt) || $past(walk_done));
endmodule

// File: tb/sim_store_buffer.sv
module sim_store_buffer;
  import sb_pkg::*;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid_i = 0, drain_ready_i = 0, inv_valid_i = 0, fill_valid_i = 0;
  logic [AW-1:0] ret_addr_i = '0;
  logic [DW-1:0] ret_data_i = '0;
  logic [1:0]  ret_size_i = 2'd2, line_sel_i = '0;
  logic        ret_ready_o, drain_valid_o, ctl_ready_o, req_o, replay_valid_o;
  logic [AW-1:0] drain_addr_o, replay_addr_o;
  logic [DW-1:0] drain_data_o, replay_data_o;
  logic [1:0]  drain_size_o, replay_size_o, req_line_o;
  logic [15:0] line_valid_o;

  always #10 clk = ~clk;

  store_buffer u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ret_valid_i, .ret_ready_o, .ret_addr_i, .ret_data_i, .ret_size_i,
    .drain_valid_o, .drain_ready_i, .drain_addr_o, .drain_data_o, .drain_size_o,
    .ctl_ready_o, .inv_valid_i, .fill_valid_i, .line_sel_i,
    .req_o, .req_line_o,
    .replay_valid_o, .replay_addr_o, .replay_data_o, .replay_size_o,
    .line_valid_o
  );

  int errors = 0, checks = 0;
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [1:0]    qs[$];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle with the current inputs; all lines assumed fully valid
  task automatic cyc();
    #1;
    if (ret_valid_i) chk("R3 ret_ready", 64'(ret_ready_o), 64'(qa.size() < DEPTH));
    chk("R2 drain_valid", 64'(drain_valid_o), 64'(qa.size() > 0));
    if (drain_valid_o && qa.size() > 0) begin
      chk("R2 addr", 64'(drain_addr_o), 64'(qa[0]));
      chk("R2 data", 64'(drain_data_o), 64'(qd[0]));
      chk("R2 size", 64'(drain_size_o), 64'(qs[0]));
    end
    if (drain_valid_o && drain_ready_i && qa.size() > 0) begin
      void'(qa.pop_front()); void'(qd.pop_front()); void'(qs.pop_front());
    end
    if (ret_valid_i && ret_ready_o) begin
      qa.push_back(ret_addr_i); qd.push_back(ret_data_i); qs.push_back(ret_size_i);
    end
    @(negedge clk);
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] s);
    ret_valid_i = 1; ret_addr_i = a; ret_data_i = d; ret_size_i = s;
    #1;
    chk("R8/R10 put accepted", 64'(ret_ready_o), 64'd1);
    @(negedge clk);
    ret_valid_i = 0;
  endtask

  initial begin
    #(64'd20 * 200000);
    errors++; checks++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] rep[$];
    logic [AW-1:0] exp_a[$];
    logic [DW-1:0] exp_d[$];
    int busy;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 drain_valid", 64'(drain_valid_o), 0);
    chk("R1 ret_ready", 64'(ret_ready_o), 1);
    chk("R1 ctl_ready", 64'(ctl_ready_o), 1);
    chk("R1 line_valid", 64'(line_valid_o), 64'hFFFF);
    chk("R1 req", 64'(req_o), 0);
    chk("R1 replay", 64'(replay_valid_o), 0);
    @(negedge clk);

    // random traffic, lines fully valid (R2, R3, R10)
    for (int i = 0; i < 600; i++) begin
      ret_valid_i   = ($urandom % 10) < 6;
      ret_addr_i    = AW'($urandom);
      ret_data_i    = $urandom;
      ret_size_i    = (($urandom % 4) == 0) ? 2'($urandom % 2) : 2'd2;
      drain_ready_i = ($urandom % 10) < 4;
      cyc();
    end
    // fill to capacity (R3)
    drain_ready_i = 0;
    ret_size_i = 2'd2;
    for (int i = 0; i < 40 && qa.size() < DEPTH; i++) begin
      ret_valid_i = 1; ret_addr_i = AW'($urandom); ret_data_i = $urandom;
      cyc();
    end
    ret_valid_i = 1; drain_ready_i = 1;
    #1;
    chk("R3 full with drain", 64'(ret_ready_o), 0);
    ret_valid_i = 0;
    for (int i = 0; i < 60 && qa.size() > 0; i++) cyc();
    drain_ready_i = 0;
    chk("R10 line bits unchanged", 64'(line_valid_o), 64'hFFFF);

    // invalidation with a queued store (R5)
    put(12'h008, 32'h1111_0000, 2'd2);
    inv_valid_i = 1; line_sel_i = 2'd1;
    #1;
    chk("R5 ctl_ready", 64'(ctl_ready_o), 1);
    @(negedge clk);
    inv_valid_i = 0;
    #1;
    chk("R5 line cleared", 64'(line_valid_o[7:4]), 0);
    chk("R5 req", 64'(req_o), 1);
    chk("R5 req_line", 64'(req_line_o), 1);
    chk("R5 entries kept", 64'(drain_valid_o), 1);
    @(negedge clk);
    #1;
    chk("R5 req one cycle", 64'(req_o), 0);
    @(negedge clk);

    // word store sets its bit (R4)
    put(12'h11C, 32'h2222_0003, 2'd2);
    #1;
    chk("R4 word bit", 64'(line_valid_o[7:4]), 64'b1000);
    @(negedge clk);
    // sub-word to incomplete line -> side buffer (R8)
    put(12'h115, 32'h0000_00AA, 2'd0);
    put(12'h112, 32'h0000_BB00, 2'd1);
    ret_valid_i = 1; ret_addr_i = 12'h116; ret_data_i = 32'hCC; ret_size_i = 2'd0;
    #1;
    chk("R8 side full stall", 64'(ret_ready_o), 0);
    @(negedge clk);
    ret_valid_i = 0;
    // sub-word to full line goes to queue (R10)
    put(12'h121, 32'h0000_DD00, 2'd0);
    put(12'h114, 32'h3333_0001, 2'd2);
    #1;
    chk("R4 second word bit", 64'(line_valid_o[7:4]), 64'b1010);
    @(negedge clk);

    // refill line 1: walk 4 entries, release 2 side entries (R6, R7, R9)
    fill_valid_i = 1; line_sel_i = 2'd1;
    ret_valid_i = 1; ret_addr_i = 12'h000; ret_data_i = 32'h5; ret_size_i = 2'd2;
    #1;
    chk("R6 fill taken", 64'(ctl_ready_o), 1);
    chk("R5 fill blocks retire", 64'(ret_ready_o), 0);
    @(negedge clk);
    fill_valid_i = 0;
    busy = 0;
    for (int i = 0; i < 30; i++) begin
      #1;
      if (ctl_ready_o) begin
        ret_valid_i = 0;
        break;
      end
      busy++;
      chk("R6 retire stalled", 64'(ret_ready_o), 0);
      if (busy <= 5) chk("R6 drain stalled", 64'(drain_valid_o), 0);
      if (replay_valid_o) rep.push_back(replay_addr_o);
      @(negedge clk);
    end
    ret_valid_i = 0;
    chk("R9 busy cycles", 64'(busy), 8);
    chk("R6 replay count", 64'(rep.size()), 2);
    if (rep.size() == 2) begin
      chk("R6 replay first", 64'(rep[0]), 64'h11C);
      chk("R6 replay second", 64'(rep[1]), 64'h114);
    end
    chk("R7 line complete", 64'(line_valid_o[7:4]), 64'hF);
    @(negedge clk);

    // drain order including released side entries (R2, R9)
    exp_a = '{12'h008, 12'h11C, 12'h121, 12'h114, 12'h115, 12'h112};
    exp_d = '{32'h1111_0000, 32'h2222_0003, 32'h0000_DD00, 32'h3333_0001,
              32'h0000_00AA, 32'h0000_BB00};
    drain_ready_i = 1;
    for (int i = 0; i < 6; i++) begin
      #1;
      chk("R9 drain valid", 64'(drain_valid_o), 1);
      chk("R9 drain addr", 64'(drain_addr_o), 64'(exp_a[i]));
      chk("R2 drain data", 64'(drain_data_o), 64'(exp_d[i]));
      @(negedge clk);
    end
    #1;
    chk("R2 empty after drain", 64'(drain_valid_o), 0);
    drain_ready_i = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule